// File: doc/BRIEF.md
# Mark-Space Carrier Modulator

This block shapes a carrier into bursts. Each modulation cycle has two phases. In the mark phase the incoming carrier is passed to the output. In the space phase the output is held low. The carrier is generated outside the block and arrives on an input pin. Software sets the mark and space lengths through byte-wide buffer registers. The working copies of those lengths are taken from the buffers only when a cycle starts or ends. A host can therefore load the next burst shape while the current one is still being sent.

Both phase counters advance on ticks from a prescaler. The prescaler divides the clock by 1, 2, 4 or 8. A status flag marks every cycle boundary, and an interrupt line mirrors that flag when the interrupt is enabled. Baseband mode drops the carrier and gives a plain high/low envelope. When software clears the enable bit, the block finishes the cycle in progress and then stops with its output low.

Top module: `mscm_top`

## Requirements
- R1: After reset, the control/status register (address 0) reads 0x00, `mod_out` is 0 and `irq` is 0.
- R2: Writing 1 to the enable bit (bit 0 of address 0) while the block is idle starts a mark phase at the next clock edge. The same edge sets the cycle flag (bit 7 of address 0).
- R3: A mark phase lasts max(M,1) ticks, where M is the working mark length. During it `mod_out` equals `carrier_in`. A space phase then lasts S ticks with `mod_out` low, where S is the working space length. S=0 skips the space phase.
- R4: Each cycle end sets the cycle flag. At each cycle end, the working mark and space lengths are reloaded from the buffers. A buffer written during a cycle affects only later cycles.
- R5: The cycle flag is cleared only by this sequence: a read of address 0 while the flag is set, followed by a read or a write of address 1 or address 3. An access to address 2 or address 4 does not clear the flag. If a flag set and a clear fall on the same edge, the set wins.
- R6: Bits 6:5 of address 0 select the tick rate: code 00 gives one tick per clock, 01 one tick per 2 clocks, 10 one per 4, and 11 one per 8.
- R7: With baseband mode set (bit 3 of address 0), `mod_out` is 1 throughout the mark phase, whatever `carrier_in` does.
- R8: `irq` is 1 exactly when the cycle flag and the interrupt-enable bit (bit 1 of address 0) are both 1.
- R9: Clearing the enable bit lets the current cycle run to its end. The block then goes idle with `mod_out` low. If the enable bit is set again before that end, the flag is not set at re-enable, and transmission continues into the next cycle.
- R10: Register map and readback:
  - Address 1 holds the mark length high byte and address 2 the low byte.
  - Address 3 holds the space length high byte and address 4 the low byte.
  - These buffers read back what was written.
  - Bits 4 and 2 of address 0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe, one clock per access |
| reg_rd | input | 1 | Read strobe, one clock per access |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| carrier_in | input | 1 | External carrier |
| mod_out | output | 1 | Modulated output |
| irq | output | 1 | Cycle-boundary interrupt |

## Verification
The assertions assume that `reg_rd` and `reg_wr` are never asserted together. They also assume that the prescaler code and the baseband bit are not changed while the sequencer is in a phase. The stimulus follows these rules:
- It issues each register access as a single one-clock strobe.
- It changes the divider or baseband setting only after the block has returned to idle.
- It changes the period buffers and the enable bit freely, including in the middle of a cycle, so that the reload and run-to-completion rules are exercised.

// File: rtl/mscm_pkg.sv
package mscm_pkg;

    localparam int PERIOD_W = 16;
    localparam int DIV_W    = 2;
    localparam int PRE_W    = (1 << DIV_W) - 1;
    localparam int ADDR_W   = 3;

    localparam logic [ADDR_W-1:0] A_CTRL     = 3'd0;
    localparam logic [ADDR_W-1:0] A_MARK_HI  = 3'd1;
    localparam logic [ADDR_W-1:0] A_MARK_LO  = 3'd2;
    localparam logic [ADDR_W-1:0] A_SPACE_HI = 3'd3;
    localparam logic [ADDR_W-1:0] A_SPACE_LO = 3'd4;

    localparam int B_FLAG  = 7;
    localparam int B_DIVLO = 5;
    localparam int B_BASE  = 3;
    localparam int B_IE    = 1;
    localparam int B_EN    = 0;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_MARK  = 2'd1,
        PH_SPACE = 2'd2
    } phase_e;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             base;
        logic             irq_en;
        logic             run_en;
    } cfg_t;

    function automatic logic [PRE_W-1:0] div_mask(input logic [DIV_W-1:0] code);
        logic [PRE_W-1:0] m;
        for (int i = 0; i < PRE_W; i++) m[i] = (i < int'(code));
        return m;
    endfunction

endpackage

// File: rtl/mscm_regs.sv
module mscm_regs
    import mscm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [7:0]          reg_wdata,
    input  logic                cyc_evt,
    output logic [7:0]          reg_rdata,
    output cfg_t                cfg,
    output logic [PERIOD_W-1:0] mark_buf,
    output logic [PERIOD_W-1:0] space_buf,
    output logic                flag
);

    localparam int NBYTES = PERIOD_W / 8;

    logic armed;
    logic hi_access;
    logic clr_hit;

    assign hi_access = (reg_rd | reg_wr) &&
                       (reg_addr == A_MARK_HI || reg_addr == A_SPACE_HI);
    assign clr_hit   = armed & hi_access;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (reg_wr && reg_addr == A_CTRL) begin
            cfg.div    <= reg_wdata[B_DIVLO +: DIV_W];
            cfg.base   <= reg_wdata[B_BASE];
            cfg.irq_en <= reg_wdata[B_IE];
            cfg.run_en <= reg_wdata[B_EN];
        end
    end

    // Byte lanes: high byte first in the map, low byte at the next address.
    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        localparam logic [ADDR_W-1:0] OFS = ADDR_W'(NBYTES - 1 - b);
        always_ff @(posedge clk) begin
            if (rst) begin
                mark_buf[b*8 +: 8]  <= '0;
                space_buf[b*8 +: 8] <= '0;
            end else if (reg_wr) begin
                if (reg_addr == A_MARK_HI + OFS)  mark_buf[b*8 +: 8]  <= reg_wdata;
                if (reg_addr == A_SPACE_HI + OFS) space_buf[b*8 +: 8] <= reg_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag  <= 1'b0;
            armed <= 1'b0;
        end else begin
            if (cyc_evt)      flag <= 1'b1;
            else if (clr_hit) flag <= 1'b0;

            if (clr_hit || cyc_evt)                      armed <= 1'b0;
            else if (reg_rd && reg_addr == A_CTRL && flag) armed <= 1'b1;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL: begin
                reg_rdata[B_FLAG]              = flag;
                reg_rdata[B_DIVLO +: DIV_W]    = cfg.div;
                reg_rdata[B_BASE]              = cfg.base;
                reg_rdata[B_IE]                = cfg.irq_en;
                reg_rdata[B_EN]                = cfg.run_en;
            end
            A_MARK_HI:  reg_rdata = mark_buf[15:8];
            A_MARK_LO:  reg_rdata = mark_buf[7:0];
            A_SPACE_HI: reg_rdata = space_buf[15:8];
            A_SPACE_LO: reg_rdata = space_buf[7:0];
            default:    reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/mscm_presc.sv
module mscm_presc
    import mscm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [PRE_W-1:0] pcnt;
    logic [PRE_W-1:0] mask;

    assign mask = div_mask(div);
    assign tick = run && ((pcnt & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || !run) pcnt <= '0;
        else             pcnt <= pcnt + 1'b1;
    end

endmodule

// File: rtl/mscm_seq.sv
module mscm_seq
    import mscm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                run_en,
    input  logic                tick,
    input  logic [PERIOD_W-1:0] mark_buf,
    input  logic [PERIOD_W-1:0] space_buf,
    output phase_e              phase,
    output logic                cyc_evt
);

    logic [PERIOD_W-1:0] cnt;
    logic [PERIOD_W-1:0] space_w;
    logic                start_now;
    logic                mark_done;
    logic                cyc_end;

    assign start_now = (phase == PH_IDLE) && run_en;
    assign mark_done = (phase == PH_MARK) && tick && (cnt <= 1);
    assign cyc_end   = (mark_done && space_w == '0) ||
                       ((phase == PH_SPACE) && tick && cnt == space_w);
    assign cyc_evt   = start_now | cyc_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            space_w <= '0;
        end else if (start_now || (cyc_end && run_en)) begin
            phase   <= PH_MARK;
            cnt     <= mark_buf;
            space_w <= space_buf;
        end else if (cyc_end) begin
            phase   <= PH_IDLE;
        end else if (mark_done) begin
            phase   <= PH_SPACE;
            cnt     <= PERIOD_W'(1);
        end else if (tick) begin
            if (phase == PH_MARK) cnt <= cnt - 1'b1;
            else                  cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/mscm_top.sv
module mscm_top
    import mscm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              carrier_in,
    output logic              mod_out,
    output logic              irq
);

    cfg_t                cfg_w;
    logic [PERIOD_W-1:0] mark_w;
    logic [PERIOD_W-1:0] space_w;
    logic                flag_w;
    logic                evt_w;
    logic                tick_w;
    phase_e              phase_w;
    logic                base_w;

    assign base_w = cfg_w.base;

    mscm_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .cyc_evt   (evt_w),
        .reg_rdata (reg_rdata),
        .cfg       (cfg_w),
        .mark_buf  (mark_w),
        .space_buf (space_w),
        .flag      (flag_w)
    );

    mscm_presc u_presc (
        .clk  (clk),
        .rst  (rst),
        .run  (phase_w != PH_IDLE),
        .div  (cfg_w.div),
        .tick (tick_w)
    );

    mscm_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .run_en    (cfg_w.run_en),
        .tick      (tick_w),
        .mark_buf  (mark_w),
        .space_buf (space_w),
        .phase     (phase_w),
        .cyc_evt   (evt_w)
    );

    assign mod_out = (phase_w == PH_MARK) && (base_w || carrier_in);
    assign irq     = flag_w && cfg_w.irq_en;

endmodule

// File: rtl/mscm_chk.sv
module mscm_chk
    import mscm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_rd,
    input logic              reg_wr,
    input logic              mod_out,
    input logic              base,
    input logic              flag,
    input logic              evt,
    input logic              tick,
    input phase_e            phase
);

    // R3
    out_only_in_mark_chk: assert property (@(posedge clk) disable iff (rst)
        mod_out |-> phase == PH_MARK);

    // R7
    base_high_chk: assert property (@(posedge clk) disable iff (rst)
        (base && phase == PH_MARK) |-> mod_out);

    // R4
    evt_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        evt |=> flag);

    // R5
    flag_clear_path_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(flag) |-> ($past(reg_rd || reg_wr) &&
                         ($past(reg_addr) == A_MARK_HI || $past(reg_addr) == A_SPACE_HI)));

    // R6
    phase_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE && !tick) |=> phase == $past(phase));

    // R2
    idle_to_mark_chk: assert property (@(posedge clk) disable iff (rst)
        phase == PH_IDLE |=> phase != PH_SPACE);

endmodule

bind mscm_top mscm_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .reg_addr (reg_addr),
    .reg_rd   (reg_rd),
    .reg_wr   (reg_wr),
    .mod_out  (mod_out),
    .base     (base_w),
    .flag     (flag_w),
    .evt      (evt_w),
    .tick     (tick_w),
    .phase    (phase_w)
);

// File: tb/mscm_top_tb_top.sv
module mscm_top_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       carrier_in = 1'b0;
    logic       mod_out;
    logic       irq;

    int n_checks = 0;
    int n_err    = 0;
    string cur_req = "R1";
    bit done = 0;

    always #2.5 clk = ~clk;

    mscm_top dut_i (
        .clk        (clk),
        .rst        (rst),
        .reg_addr   (reg_addr),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .carrier_in (carrier_in),
        .mod_out    (mod_out),
        .irq        (irq)
    );

    // ---------------- behavioural reference ----------------
    int  m_state = 0;        // 0 idle, 1 mark, 2 space
    int  m_cnt = 0, m_sw = 0, m_pc = 0;
    bit  m_flag = 0, m_arm = 0;
    int  m_div = 0;
    bit  m_base = 0, m_ie = 0, m_en = 0;
    int  m_mark = 0, m_space = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_state = 0; m_cnt = 0; m_sw = 0; m_pc = 0;
            m_flag = 0; m_arm = 0; m_div = 0; m_base = 0; m_ie = 0; m_en = 0;
            m_mark = 0; m_space = 0;
        end else begin
            int  per;
            bit  tk, ev, endc, hi, clr;
            per  = 1 << m_div;
            tk   = (m_state != 0) && ((m_pc % per) == per - 1);
            ev   = 0;
            endc = 0;
            if (m_state == 0) begin
                m_pc = 0;
                if (m_en) begin
                    m_state = 1; m_cnt = m_mark; m_sw = m_space; ev = 1;
                end
            end else begin
                m_pc = (m_pc + 1) % 8;
                if (tk) begin
                    if (m_state == 1) begin
                        if (m_cnt <= 1) begin
                            if (m_sw == 0) endc = 1;
                            else begin m_state = 2; m_cnt = 1; end
                        end else m_cnt--;
                    end else begin
                        if (m_cnt == m_sw) endc = 1;
                        else m_cnt++;
                    end
                end
                if (endc) begin
                    ev = 1;
                    if (m_en) begin m_state = 1; m_cnt = m_mark; m_sw = m_space; end
                    else m_state = 0;
                end
            end
            hi  = (reg_rd || reg_wr) && (reg_addr == 1 || reg_addr == 3);
            clr = m_arm && hi;
            if (clr || ev) m_arm = 0;
            else if (reg_rd && reg_addr == 0 && m_flag) m_arm = 1;
            if (ev) m_flag = 1;
            else if (clr) m_flag = 0;
            if (reg_wr) begin
                case (reg_addr)
                    0: begin m_div = int'(reg_wdata[6:5]); m_base = reg_wdata[3];
                             m_ie = reg_wdata[1]; m_en = reg_wdata[0]; end
                    1: m_mark  = (m_mark & 'hFF) | (int'(reg_wdata) << 8);
                    2: m_mark  = (m_mark & 'hFF00) | int'(reg_wdata);
                    3: m_space = (m_space & 'hFF) | (int'(reg_wdata) << 8);
                    4: m_space = (m_space & 'hFF00) | int'(reg_wdata);
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [7:0] exp_rdata();
        case (reg_addr)
            3'd0: return {m_flag, 2'(m_div), 1'b0, m_base, 1'b0, m_ie, m_en};
            3'd1: return 8'(m_mark >> 8);
            3'd2: return 8'(m_mark);
            3'd3: return 8'(m_space >> 8);
            3'd4: return 8'(m_space);
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int got, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s got=%0h exp=%0h", req, what, got, exp);
        end
    endtask

    // per-clock comparison, sampled on the falling edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            bit eo, ei;
            eo = (m_state == 1) && (m_base || carrier_in);
            ei = m_flag && m_ie;
            check(mod_out == eo, cur_req, "mod_out", int'(mod_out), int'(eo));
            check(irq == ei, "R8", "irq", int'(irq), int'(ei));
            check(reg_rdata == exp_rdata(), cur_req, "rdata",
                  int'(reg_rdata), int'(exp_rdata()));
        end
    end

    // carrier stimulus: toggles every third clock, off the active edge
    int ccnt = 0;
    always @(posedge clk) begin
        #1;
        ccnt++;
        if (ccnt % 3 == 0) carrier_in = ~carrier_in;
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a);
        @(posedge clk); #1;
        reg_addr = a; reg_rd = 1'b1;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic wait_stop();
        for (int i = 0; i < 2000 && m_state != 0; i++) @(posedge clk);
        #1;
    endtask

    initial begin : watchdog
        #(5 * 150000);
        n_checks++;
        n_err++;
        $display("FAIL watchdog expired in %s", cur_req);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin : stim
        idle(3);
        rst = 1'b0;
        #1;
        @(negedge clk);
        cur_req = "R1";
        check(reg_rdata == 8'h00, "R1", "ctrl after reset", int'(reg_rdata), 0);
        check(mod_out == 1'b0, "R1", "mod_out after reset", int'(mod_out), 0);
        check(irq == 1'b0, "R1", "irq after reset", int'(irq), 0);

        cur_req = "R10";
        wr(3'd1, 8'h00); wr(3'd2, 8'h03); wr(3'd3, 8'h00); wr(3'd4, 8'h02);
        wr(3'd0, 8'hFF & ~8'h01 & ~8'h08);  // div 3, ie, bits 4 and 2 written 1
        @(negedge clk);
        check(reg_rdata[4] == 1'b0 && reg_rdata[2] == 1'b0, "R10", "reserved bits",
              int'(reg_rdata), 0);
        wr(3'd0, 8'h00);

        cur_req = "R2";
        wr(3'd0, 8'h01);
        idle(12);
        cur_req = "R3";
        idle(20);

        cur_req = "R4";
        wr(3'd2, 8'h01); wr(3'd4, 8'h00);
        idle(10);
        wr(3'd2, 8'h05); wr(3'd4, 8'h04);
        idle(30);

        cur_req = "R5";
        rd(3'd0);
        wr(3'd2, 8'h05);   // low-byte access: must not clear
        rd(3'd4);
        idle(1);
        rd(3'd1);          // high-byte access after status read: clears
        idle(3);
        rd(3'd0);
        wr(3'd3, 8'h00);
        idle(4);

        cur_req = "R8";
        wr(3'd0, 8'h03);
        idle(25);
        rd(3'd0); rd(3'd3);
        idle(10);

        cur_req = "R9";
        wr(3'd0, 8'h00);
        wait_stop();
        idle(8);
        wr(3'd2, 8'h00);   // mark length 0 behaves as 1
        wr(3'd0, 8'h01);
        idle(6);
        wr(3'd2, 8'h08); wr(3'd4, 8'h06);
        idle(16);
        wr(3'd0, 8'h00);
        idle(2);
        wr(3'd0, 8'h01);   // re-enable before the current cycle finishes
        idle(40);
        wr(3'd0, 8'h00);
        wait_stop();

        cur_req = "R6";
        for (int d = 1; d < 4; d++) begin
            wr(3'd0, 8'((d << 5) | 1));
            idle(70);
            wr(3'd0, 8'(d << 5));
            wait_stop();
            idle(3);
        end

        cur_req = "R7";
        wr(3'd0, 8'h09);
        idle(40);
        wr(3'd0, 8'h08);
        wait_stop();
        idle(5);

        cur_req = "R10";
        wr(3'd1, 8'hA5);
        @(negedge clk);
        check(reg_rdata == 8'hA5, "R10", "mark high readback", int'(reg_rdata), 'hA5);
        wr(3'd4, 8'h3C);
        @(negedge clk);
        check(reg_rdata == 8'h3C, "R10", "space low readback", int'(reg_rdata), 'h3C);
        idle(2);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule